// File: doc/BRIEF.md
# Ordered Work-Group Dispatcher

This block takes one kernel launch at a time and turns it into a stream of work-group indices for four shader engines. A launch carries the number of work-groups, the thread count of each group and a flat 60-bit compute-unit enable mask. The dispatcher issues indices 0, 1, 2 and so on, strictly in ascending order. It offers each index to exactly one engine through that engine's valid/ready pair. Each index goes with the group's thread count and with the 15-bit CU enable vector of the engine that receives it.

Engines are visited in a fixed cyclic order. An engine is passed over only if the mask enables none of its CUs. A busy engine is never passed over: the dispatcher waits on it, even while other engines are ready. Compute units are interleaved in the flat mask, so neighbouring mask bits land on different engines. A launch that cannot run is refused at once with an error pulse, and no work-group is sent. The reasons are no enabled CU, a zero or oversized thread count, or a zero group count. A one-cycle completion pulse follows the acceptance of the last group. The dispatcher is then ready for the next launch.

Top module: `wg_ordered_dispatch`

## Requirements
- R1: Work-group indices start at 0 for every launch and rise by exactly one per acceptance. The next index is presented only after the previous one has been accepted.
- R2: At most one bit of `engValid` is high in any cycle. `blockIdx`, `blockThreads` and `engCuEn` belong to the engine whose valid bit is high. After reset no engine is valid and `startReady` is high.
- R3: After each acceptance, the next engine is the next eligible engine in the cyclic order 0, 1, 2, 3, 0, and so on. With all engines eligible, group k goes to engine k mod 4.
- R4: While the current engine's `engReady` is low, its valid bit, `blockIdx` and `engCuEn` hold. No other engine becomes valid during that time.
- R5: An engine whose 15 CU enables are all zero is never made valid for that launch. Such an engine is skipped in the rotation.
- R6: Flat mask bit i enables CU (i div 4) of engine (i mod 4). `engCuEn` bit c for engine e equals `cuMask[4*c+e]`.
- R7: The first group of every launch goes to the lowest-numbered eligible engine.
- R8: `kernelDone` is high for exactly one cycle. That cycle is the one after the final index was accepted. In that cycle `startReady` is high and no engine is valid.
- R9: A launch is taken when `startValid` and `startReady` are both high. The launch is refused if the mask is all zero, if the thread count is 0 or above 1024, or if the group count is 0. A refused launch raises `reqError` for one cycle in the next cycle, sends no group, and leaves `startReady` high.
- R10: `blockThreads` carries the thread count given at launch for every group of that launch. A thread count of exactly 1024 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Launch request present |
| startReady | output | 1 | Dispatcher idle, launch will be taken |
| blockCount | input | 16 | Number of work-groups in the launch |
| threadsPerBlock | input | 11 | Threads per work-group |
| cuMask | input | 60 | Flat interleaved CU enable mask |
| engValid | output | 4 | Per-engine offer of the current group |
| engReady | input | 4 | Per-engine acceptance |
| blockIdx | output | 16 | Index of the offered work-group |
| blockThreads | output | 11 | Thread count of the offered work-group |
| engCuEn | output | 15 | CU enables of the engine being offered the group |
| kernelDone | output | 1 | One-cycle pulse after the last group is accepted |
| reqError | output | 1 | One-cycle pulse for a refused launch |

## Verification
A wrong rotation pointer shows in the very cycle after the acceptance that corrupted it. Either the wrong `engValid` bit rises, or the `engCuEn` vector belongs to another engine. Both show up when compared against a behavioural model on every clock. A bad index counter is seen at the next offered `blockIdx`, or as a `kernelDone` pulse that comes too early or too late. A mis-routed mask bit shows as soon as the affected engine is first offered a group. A stall that does not hold is caught in the first cycle where a not-ready engine loses its offer or another engine's offer appears.

// File: rtl/wgd_pkg.sv
package wgd_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;  // capture a new launch
    logic step;  // advance to the next index and engine
  } wgdStrobe_t;
endpackage

// File: rtl/wgd_path.sv
module wgd_path
  import wgd_pkg::*;
#(
  parameter int NE    = 4,
  parameter int CPE   = 15,
  parameter int IDX_W = 16,
  parameter int THR_W = 11,
  parameter int MAXT  = 1024,
  localparam int MW    = NE * CPE,
  localparam int ENG_W = $clog2(NE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wgdStrobe_t        strobe,
  input  logic [IDX_W-1:0]  blockCount,
  input  logic [THR_W-1:0]  threadsPerBlock,
  input  logic [MW-1:0]     cuMask,
  input  logic [NE-1:0]     engReady,
  output logic              reqOk,
  output logic              curReady,
  output logic              lastBlk,
  output logic [ENG_W-1:0]  engSel,
  output logic [IDX_W-1:0]  blockIdx,
  output logic [THR_W-1:0]  blockThreads,
  output logic [CPE-1:0]    engCuEn
);
  logic [NE-1:0][CPE-1:0] sliceIn, sliceQ;
  logic [NE-1:0]          eligIn, eligQ;
  logic [ENG_W-1:0]       firstElig, nextEng, curQ;
  logic [IDX_W-1:0]       idxQ, cntQ;
  logic [THR_W-1:0]       thrQ;

  // De-interleave the flat mask: bit c*NE+e belongs to engine e, CU c
  for (genvar e = 0; e < NE; e++) begin : g_eng
    for (genvar c = 0; c < CPE; c++) begin : g_cu
      assign sliceIn[e][c] = cuMask[c*NE + e];
    end
    assign eligIn[e] = |sliceIn[e];
  end

  assign reqOk = (|eligIn) && (threadsPerBlock != '0) &&
                 (int'(threadsPerBlock) <= MAXT) && (blockCount != '0);

  // Lowest-numbered eligible engine of the incoming launch
  always_comb begin
    firstElig = '0;
    for (int e = NE - 1; e >= 0; e--) begin
      if (eligIn[e]) firstElig = ENG_W'(e);
    end
  end

  // Next eligible engine after the current one, cyclically
  always_comb begin
    logic found;
    logic [ENG_W-1:0] cand;
    found   = 1'b0;
    nextEng = curQ;
    for (int k = 1; k <= NE; k++) begin
      cand = ENG_W'((int'(curQ) + k) % NE);
      if (!found && eligQ[cand]) begin
        nextEng = cand;
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sliceQ <= '0;
      eligQ  <= '0;
      curQ   <= '0;
      idxQ   <= '0;
      cntQ   <= '0;
      thrQ   <= '0;
    end else if (strobe.load) begin
      sliceQ <= sliceIn;
      eligQ  <= eligIn;
      curQ   <= firstElig;
      idxQ   <= '0;
      cntQ   <= blockCount;
      thrQ   <= threadsPerBlock;
    end else if (strobe.step) begin
      idxQ <= idxQ + 1'b1;
      curQ <= nextEng;
    end
  end

  assign curReady     = engReady[curQ];
  assign lastBlk      = (idxQ == cntQ - 1'b1);
  assign engSel       = curQ;
  assign blockIdx     = idxQ;
  assign blockThreads = thrQ;
  assign engCuEn      = sliceQ[curQ];
endmodule

// File: rtl/wgd_ctrl.sv
module wgd_ctrl
  import wgd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       reqOk,
  input  logic       curReady,
  input  logic       lastBlk,
  output wgdStrobe_t strobe,
  output logic       busy,
  output logic       kernelDone,
  output logic       reqError
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t stateQ;
  logic   finish, reject;

  assign busy        = (stateQ == ST_RUN);
  assign strobe.load = !busy && startValid && reqOk;
  assign reject      = !busy && startValid && !reqOk;
  assign strobe.step = busy && curReady && !lastBlk;
  assign finish      = busy && curReady && lastBlk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      kernelDone <= 1'b0;
      reqError   <= 1'b0;
    end else begin
      kernelDone <= finish;
      reqError   <= reject;
      if (strobe.load)  stateQ <= ST_RUN;
      else if (finish)  stateQ <= ST_IDLE;
    end
  end
endmodule

// File: rtl/wg_ordered_dispatch.sv
module wg_ordered_dispatch
  import wgd_pkg::*;
#(
  parameter int NE    = 4,
  parameter int CPE   = 15,
  parameter int IDX_W = 16,
  parameter int THR_W = 11,
  parameter int MAXT  = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startValid,
  output logic                startReady,
  input  logic [IDX_W-1:0]    blockCount,
  input  logic [THR_W-1:0]    threadsPerBlock,
  input  logic [NE*CPE-1:0]   cuMask,
  output logic [NE-1:0]       engValid,
  input  logic [NE-1:0]       engReady,
  output logic [IDX_W-1:0]    blockIdx,
  output logic [THR_W-1:0]    blockThreads,
  output logic [CPE-1:0]      engCuEn,
  output logic                kernelDone,
  output logic                reqError
);
  localparam int ENG_W = $clog2(NE);

  wgdStrobe_t       strobe;
  logic             busy, reqOk, curReady, lastBlk;
  logic [ENG_W-1:0] engSel;

  wgd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .reqOk(reqOk),
    .curReady(curReady), .lastBlk(lastBlk), .strobe(strobe), .busy(busy),
    .kernelDone(kernelDone), .reqError(reqError)
  );

  wgd_path #(.NE(NE), .CPE(CPE), .IDX_W(IDX_W), .THR_W(THR_W), .MAXT(MAXT)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .blockCount(blockCount),
    .threadsPerBlock(threadsPerBlock), .cuMask(cuMask), .engReady(engReady),
    .reqOk(reqOk), .curReady(curReady), .lastBlk(lastBlk), .engSel(engSel),
    .blockIdx(blockIdx), .blockThreads(blockThreads), .engCuEn(engCuEn)
  );

  for (genvar e = 0; e < NE; e++) begin : g_valid
    assign engValid[e] = busy && (engSel == ENG_W'(e));
  end

  assign startReady = !busy;
endmodule

// File: rtl/wgd_checker.sv
module wgd_checker #(
  parameter int NE    = 4,
  parameter int CPE   = 15,
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReady,
  input logic [NE-1:0]    engValid,
  input logic [NE-1:0]    engReady,
  input logic [IDX_W-1:0] blockIdx,
  input logic [CPE-1:0]   engCuEn,
  input logic             kernelDone,
  input logic             reqError
);
  // R2: a single engine is offered a group at a time
  a_r2_one_engine: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(engValid));

  // R4: a stalled offer holds its engine and its index
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (|(engValid & ~engReady)) |=> ($stable(engValid) && $stable(blockIdx)));

  // R1: an accepted group is followed by the next index or by completion
  a_r1_next_index: assert property (@(posedge clk) disable iff (!rstN)
    (|(engValid & engReady)) |=>
      (kernelDone || (blockIdx == IDX_W'($past(blockIdx) + 1'b1))));

  // R5: an offered engine always has at least one enabled CU
  a_r5_no_empty_engine: assert property (@(posedge clk) disable iff (!rstN)
    (|engValid) |-> (|engCuEn));

  // R8: completion comes with the idle state and lasts one cycle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    kernelDone |-> (startReady && (engValid == '0)));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    kernelDone |=> !kernelDone);

  // R9: a refused launch dispatches nothing
  a_r9_error_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqError |-> (startReady && (engValid == '0)));
endmodule

bind wg_ordered_dispatch wgd_checker #(.NE(NE), .CPE(CPE), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_wg_ordered_dispatch.sv
`timescale 1ns/1ps
module sim_wg_ordered_dispatch;
  localparam int NE = 4, CPE = 15, IDX_W = 16, THR_W = 11, MW = NE * CPE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic             startValid = 1'b0;
  logic [IDX_W-1:0] blockCount = '0;
  logic [THR_W-1:0] threadsPerBlock = '0;
  logic [MW-1:0]    cuMask = '0;
  logic [NE-1:0]    engReady = '0;
  logic             startReady, kernelDone, reqError;
  logic [NE-1:0]    engValid;
  logic [IDX_W-1:0] blockIdx;
  logic [THR_W-1:0] blockThreads;
  logic [CPE-1:0]   engCuEn;

  wg_ordered_dispatch u0 (.*);

  int total = 0, bad = 0;

  // Behavioural reference state
  bit       mBusy = 0, mDone = 0, mErr = 0;
  int       mIdx, mCnt, mThr, mCur;
  bit       mElig [NE];
  int       mSlice [NE];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareOut();
    logic [NE-1:0] ev;
    ev = mBusy ? NE'(1 << mCur) : '0;
    check("R9 startReady", startReady, !mBusy);
    check("R2 R3 R4 R5 R7 engValid", engValid, ev);
    if (mBusy) begin
      check("R1 blockIdx", blockIdx, mIdx);
      check("R6 engCuEn", engCuEn, mSlice[mCur]);
      check("R10 blockThreads", blockThreads, mThr);
    end
    check("R8 kernelDone", kernelDone, mDone);
    check("R9 reqError", reqError, mErr);
  endtask

  function automatic int nextElig(int from);
    for (int k = 1; k <= NE; k++) begin
      if (mElig[(from + k) % NE]) return (from + k) % NE;
    end
    return from;
  endfunction

  task automatic modelUpdate();
    mDone = 0;
    mErr  = 0;
    if (!mBusy && startValid) begin
      int anyCu = 0;
      for (int e = 0; e < NE; e++) mSlice[e] = 0;
      for (int i = 0; i < MW; i++) begin
        if (cuMask[i]) begin
          mSlice[i % NE] = mSlice[i % NE] | (1 << (i / NE));
          anyCu = 1;
        end
      end
      if (!anyCu || threadsPerBlock == 0 || threadsPerBlock > 1024 || blockCount == 0) begin
        mErr = 1;
      end else begin
        mBusy = 1;
        mIdx  = 0;
        mCnt  = blockCount;
        mThr  = threadsPerBlock;
        mCur  = -1;
        for (int e = 0; e < NE; e++) begin
          mElig[e] = (mSlice[e] != 0);
          if (mElig[e] && mCur < 0) mCur = e;
        end
      end
    end else if (mBusy && engReady[mCur]) begin
      if (mIdx == mCnt - 1) begin
        mBusy = 0;
        mDone = 1;
      end else begin
        mIdx++;
        mCur = nextElig(mCur);
      end
    end
  endtask

  task automatic tick();
    compareOut();
    modelUpdate();
    @(negedge clk);
  endtask

  function automatic logic [NE-1:0] randReady(int pct);
    logic [NE-1:0] r;
    for (int e = 0; e < NE; e++) r[e] = ($urandom_range(0, 99) < pct);
    return r;
  endfunction

  task automatic runKernel(int cnt, int thr, logic [MW-1:0] mask, int pct);
    startValid      = 1'b1;
    blockCount      = IDX_W'(cnt);
    threadsPerBlock = THR_W'(thr);
    cuMask          = mask;
    engReady        = randReady(pct);
    tick();
    startValid = 1'b0;
    while (mBusy || mDone || mErr) begin
      engReady = randReady(pct);
      tick();
    end
  endtask

  function automatic logic [MW-1:0] killEngines(logic [MW-1:0] m, logic [NE-1:0] kill);
    for (int i = 0; i < MW; i++) if (kill[i % NE]) m[i] = 1'b0;
    return m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [MW-1:0] full;
    full = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // Reset state (R2)
    check("R2 reset engValid", engValid, '0);
    check("R2 reset startReady", startReady, 1'b1);
    check("R8 reset kernelDone", kernelDone, 1'b0);
    tick();

    // R3: all engines eligible, always ready: group k to engine k mod 4
    runKernel(10, 256, full, 100);
    // R4: heavy stalls with all engines
    runKernel(17, 1024, full, 30);
    // R5 R7: engines 0 and 2 masked off, first group to engine 1
    runKernel(13, 64, killEngines(full, 4'b0101), 60);
    // R7: only engine 3 eligible
    runKernel(5, 32, killEngines(full, 4'b0111), 70);
    // R6: single CU enabled on engine 2 (bit 4*7+2)
    runKernel(6, 8, MW'(1) << 30, 80);
    // R1: single-group launch
    runKernel(1, 1, full, 50);

    // R9: refused launches
    runKernel(4, 64, '0, 100);
    runKernel(4, 1025, full, 100);
    runKernel(4, 0, full, 100);
    runKernel(0, 64, full, 100);
    check("R9 idle after refusals", startReady, 1'b1);

    // Random launches over random masks and ready patterns
    for (int n = 0; n < 150; n++) begin
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      runKernel($urandom_range(0, 40), $urandom_range(0, 1100),
                killEngines(r[MW-1:0], NE'($urandom_range(0, 15))),
                $urandom_range(10, 100));
      if ($urandom_range(0, 3) == 0) tick();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule